// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block turns a one-cycle trap request into the architectural updates a hart makes when it takes a trap. A request carries a cause word, the PC of the trapping instruction and a trap value. The surrounding core supplies the current privilege, the machine and supervisor interrupt-enable bits, the debug-mode flag, the per-privilege breakpoint-to-debug enables, the two delegation masks and both trap vectors. On the next cycle the block presents one update record. The record gives the route the trap took, the next PC and the new privilege. It also gives the cause, exception-PC and trap value for the target level, plus the new enable, previous-enable and previous-privilege bits. The core writes these into its CSRs and PC.

The route is one of four: a redirect while debug mode is already active, entry into debug mode on an enabled breakpoint, entry at supervisor level, or entry at machine level. Machine-level entry supports a vectored mode for interrupts. In that mode the target PC is the vector base plus four times the cause index.

Top module: `trap_entry_ctrl`

## Requirements
- R1: When `trap_valid_i` is high at a rising edge, `upd_o` is high during the following cycle only, and the whole record reflects that request. While no request is taken, `upd_o` stays low and every record output keeps its value.
- R2: With `dbg_mode_i` high, the route is 0 and the privilege is unchanged. A breakpoint (cause word exactly 3) sends the PC to `DBG_ENTRY_ADDR`. Any other cause sends it to `DBG_EXC_ADDR`. Cause, exception PC, trap value, enable, previous-enable and previous-privilege outputs keep their values.
- R3: Outside debug mode, a breakpoint taken at user (0), supervisor (1) or machine (3) privilege enters debug mode when that privilege's ebreak enable is set. The route is 1 and the PC is `DBG_ENTRY_ADDR`. Privilege becomes 3, the cause output is `DBG_SWBP_CODE`, the exception PC is the request PC and the previous privilege is the current privilege. Trap value, enable and previous-enable keep their values.
- R4: Bit XLEN-1 of the cause marks an interrupt. Interrupts consult `ideleg_i` and exceptions consult `edeleg_i`, at the bit given by the cause with its top bit cleared.
- R5: A trap goes to supervisor only if three conditions hold: the current privilege is 0 or 1, the cause index is below XLEN, and the selected delegation bit is set. Otherwise it goes to machine.
- R6: On supervisor entry the route is 2, the PC is `stvec_i` and privilege becomes 1. Cause, exception PC and trap value come from the request. Previous-enable takes `sie_i`, previous privilege takes the current privilege, and the enable becomes 0.
- R7: On machine entry, if bit 0 of `mtvec_i` is set and the trap is an interrupt, the PC is `mtvec_i` with bit 0 cleared plus 4 times the cause index. Otherwise the PC is `mtvec_i` with bit 0 cleared.
- R8: On machine entry the route is 3 and privilege becomes 3. Cause, exception PC and trap value come from the request. Previous-enable takes `mie_i`, previous privilege takes the current privilege, and the enable becomes 0.
- R9: After reset `upd_o` is 0, `pc_o` is 0 and `priv_o` is 3.
- R10: A breakpoint whose ebreak enable for the current privilege is clear is treated as an ordinary exception with cause index 3, delegated per R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_valid_i | input | 1 | One-cycle trap request |
| trap_cause_i | input | XLEN | Cause word, top bit marks an interrupt |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_tval_i | input | XLEN | Trap value |
| cur_priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mie_i | input | 1 | Current machine interrupt enable |
| sie_i | input | 1 | Current supervisor interrupt enable |
| dbg_mode_i | input | 1 | Debug mode already active |
| ebrk_m_i | input | 1 | Breakpoint at machine level enters debug |
| ebrk_s_i | input | 1 | Breakpoint at supervisor level enters debug |
| ebrk_u_i | input | 1 | Breakpoint at user level enters debug |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| mtvec_i | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| stvec_i | input | XLEN | Supervisor trap vector |
| upd_o | output | 1 | Update record valid |
| path_o | output | 2 | Route: 0 debug redirect, 1 debug entry, 2 supervisor, 3 machine |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | New privilege |
| cause_o | output | XLEN | Cause to record at the target level |
| epc_o | output | XLEN | Exception PC to record |
| tval_o | output | XLEN | Trap value to record |
| ie_o | output | 1 | New enable of the target level |
| pie_o | output | 1 | New previous-enable of the target level |
| pp_o | output | 2 | New previous privilege |

## Verification
Every result of a request is due exactly one cycle after the edge that samples `trap_valid_i`, because the whole record passes through a single register stage. The driver applies each request at a falling edge and queues its expected record. The monitor samples at the next falling edge, when `upd_o` must be high. Outputs therefore never change near the sampling point. The hold checks let several idle falling edges pass before comparing outputs, so a stray update would show up in those comparisons.

// File: rtl/trap_pkg.sv
// Package: shared encodings for the trap entry controller.
// Assumes privilege values 0/1/3 and a 2-bit route code that the core decodes.
package trap_pkg;

    typedef enum logic [1:0] {
        PATH_DBG_REDIR = 2'd0,
        PATH_DBG_ENTER = 2'd1,
        PATH_SUP       = 2'd2,
        PATH_MACH      = 2'd3
    } trap_path_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // exception code of a breakpoint
    localparam int unsigned BKPT_CODE = 3;

endpackage

// File: rtl/trap_deleg.sv
// Delegation decision: splits the cause into interrupt flag and index,
// selects the interrupt or exception mask and decides supervisor handling.
// Assumes XLEN is a power of two.
module trap_deleg #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause_i,
    input  logic [1:0]      priv_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] ideleg_i,
    output logic            is_irq_o,
    output logic [XLEN-1:0] idx_o,
    output logic            to_sup_o
);
    import trap_pkg::*;

    localparam int IDXW = $clog2(XLEN);

    logic [XLEN-1:0] mask;
    logic            in_range;
    logic            low_priv;

    // Purpose: compute interrupt flag, index, mask and the delegation result.
    always_comb begin
        is_irq_o = cause_i[XLEN-1];
        idx_o    = {1'b0, cause_i[XLEN-2:0]};
        mask     = is_irq_o ? ideleg_i : edeleg_i;
        in_range = (idx_o[XLEN-1:IDXW] == '0);
        low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_sup_o = low_priv && in_range && mask[idx_o[IDXW-1:0]];
    end

endmodule

// File: rtl/trap_bkpt.sv
// Breakpoint classifier: detects a breakpoint cause and decides whether it
// enters debug mode under the per-privilege enables. Assumes debug mode
// not yet active; the caller gives the redirect route priority.
module trap_bkpt #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause_i,
    input  logic [1:0]      priv_i,
    input  logic            ebrk_m_i,
    input  logic            ebrk_s_i,
    input  logic            ebrk_u_i,
    output logic            is_bkpt_o,
    output logic            enter_dbg_o
);
    import trap_pkg::*;

    logic priv_en;

    // Purpose: pick the enable for the current privilege and qualify it.
    always_comb begin
        is_bkpt_o = (cause_i == XLEN'(BKPT_CODE));
        unique case (priv_i)
            PRIV_U:  priv_en = ebrk_u_i;
            PRIV_S:  priv_en = ebrk_s_i;
            PRIV_M:  priv_en = ebrk_m_i;
            default: priv_en = 1'b0;
        endcase
        enter_dbg_o = is_bkpt_o && priv_en;
    end

endmodule

// File: rtl/trap_target.sv
// Target PC selection for the four routes, including the vectored
// machine-interrupt address. Assumes idx_i already has the top bit cleared.
module trap_target #(
    parameter int              XLEN           = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY_ADDR = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR   = 'h808
) (
    input  logic [1:0]      path_i,
    input  logic            is_bkpt_i,
    input  logic            is_irq_i,
    input  logic [XLEN-1:0] idx_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [XLEN-1:0] stvec_i,
    output logic [XLEN-1:0] pc_o
);
    import trap_pkg::*;

    logic [XLEN-1:0] mbase;
    logic [XLEN-1:0] moffs;

    // Purpose: form machine base and offset, then mux by route.
    always_comb begin
        mbase = {mtvec_i[XLEN-1:1], 1'b0};
        moffs = (mtvec_i[0] && is_irq_i) ? (idx_i << 2) : '0;
        unique case (path_i)
            PATH_DBG_REDIR: pc_o = is_bkpt_i ? DBG_ENTRY_ADDR : DBG_EXC_ADDR;
            PATH_DBG_ENTER: pc_o = DBG_ENTRY_ADDR;
            PATH_SUP:       pc_o = stvec_i;
            default:        pc_o = mbase + moffs;
        endcase
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap entry controller top: routes a one-cycle trap request and registers
// one update record (PC, privilege, cause/epc/tval and status stacking).
// Assumes the core applies the record in the cycle upd_o is high.
module trap_entry_ctrl #(
    parameter int              XLEN           = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY_ADDR = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR   = 'h808,
    parameter int unsigned     DBG_SWBP_CODE  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid_i,
    input  logic [XLEN-1:0] trap_cause_i,
    input  logic [XLEN-1:0] trap_epc_i,
    input  logic [XLEN-1:0] trap_tval_i,
    input  logic [1:0]      cur_priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            dbg_mode_i,
    input  logic            ebrk_m_i,
    input  logic            ebrk_s_i,
    input  logic            ebrk_u_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] ideleg_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [XLEN-1:0] stvec_i,
    output logic            upd_o,
    output logic [1:0]      path_o,
    output logic [XLEN-1:0] pc_o,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] tval_o,
    output logic            ie_o,
    output logic            pie_o,
    output logic [1:0]      pp_o
);
    import trap_pkg::*;

    localparam logic [XLEN-1:0] SWBP_CAUSE = XLEN'(DBG_SWBP_CODE);

    logic            is_irq;
    logic [XLEN-1:0] idx;
    logic            to_sup;
    logic            is_bkpt;
    logic            enter_dbg;
    trap_path_e      path_n;
    logic [XLEN-1:0] pc_n;

    trap_deleg #(.XLEN(XLEN)) u_deleg (
        .cause_i  (trap_cause_i),
        .priv_i   (cur_priv_i),
        .edeleg_i (edeleg_i),
        .ideleg_i (ideleg_i),
        .is_irq_o (is_irq),
        .idx_o    (idx),
        .to_sup_o (to_sup)
    );

    trap_bkpt #(.XLEN(XLEN)) u_bkpt (
        .cause_i     (trap_cause_i),
        .priv_i      (cur_priv_i),
        .ebrk_m_i    (ebrk_m_i),
        .ebrk_s_i    (ebrk_s_i),
        .ebrk_u_i    (ebrk_u_i),
        .is_bkpt_o   (is_bkpt),
        .enter_dbg_o (enter_dbg)
    );

    // Purpose: route priority - redirect, debug entry, supervisor, machine.
    always_comb begin
        if (dbg_mode_i)     path_n = PATH_DBG_REDIR;
        else if (enter_dbg) path_n = PATH_DBG_ENTER;
        else if (to_sup)    path_n = PATH_SUP;
        else                path_n = PATH_MACH;
    end

    trap_target #(
        .XLEN           (XLEN),
        .DBG_ENTRY_ADDR (DBG_ENTRY_ADDR),
        .DBG_EXC_ADDR   (DBG_EXC_ADDR)
    ) u_target (
        .path_i    (path_n),
        .is_bkpt_i (is_bkpt),
        .is_irq_i  (is_irq),
        .idx_i     (idx),
        .mtvec_i   (mtvec_i),
        .stvec_i   (stvec_i),
        .pc_o      (pc_n)
    );

    // Purpose: register the update record in the cycle the request is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_o   <= 1'b0;
            path_o  <= PATH_MACH;
            pc_o    <= '0;
            priv_o  <= PRIV_M;
            cause_o <= '0;
            epc_o   <= '0;
            tval_o  <= '0;
            ie_o    <= 1'b0;
            pie_o   <= 1'b0;
            pp_o    <= PRIV_U;
        end else begin
            upd_o <= trap_valid_i;
            if (trap_valid_i) begin
                path_o <= path_n;
                pc_o   <= pc_n;
                unique case (path_n)
                    PATH_DBG_REDIR: priv_o <= cur_priv_i;
                    PATH_DBG_ENTER: begin
                        priv_o  <= PRIV_M;
                        cause_o <= SWBP_CAUSE;
                        epc_o   <= trap_epc_i;
                        pp_o    <= cur_priv_i;
                    end
                    PATH_SUP: begin
                        priv_o  <= PRIV_S;
                        cause_o <= trap_cause_i;
                        epc_o   <= trap_epc_i;
                        tval_o  <= trap_tval_i;
                        pie_o   <= sie_i;
                        ie_o    <= 1'b0;
                        pp_o    <= cur_priv_i;
                    end
                    default: begin
                        priv_o  <= PRIV_M;
                        cause_o <= trap_cause_i;
                        epc_o   <= trap_epc_i;
                        tval_o  <= trap_tval_i;
                        pie_o   <= mie_i;
                        ie_o    <= 1'b0;
                        pp_o    <= cur_priv_i;
                    end
                endcase
            end
        end
    end

    // R1
    upd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> upd_o);
    // R1
    upd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> (!upd_o && $stable(pc_o) && $stable(priv_o)));
    // R2
    dbg_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && dbg_mode_i) |=>
        (path_o == PATH_DBG_REDIR && priv_o == $past(cur_priv_i)));
    // R5
    no_sup_from_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !dbg_mode_i && cur_priv_i == PRIV_M) |=> (path_o != PATH_SUP));
    // R8
    mach_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && path_o == PATH_MACH) |-> (priv_o == PRIV_M && !ie_o));
    // R6
    sup_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !dbg_mode_i && !enter_dbg && to_sup) |=>
        (priv_o == PRIV_S && !ie_o && pie_o == $past(sie_i)));

endmodule

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
    localparam int XLEN = 32;
    localparam logic [31:0] ENTRY = 32'h0000_0800;
    localparam logic [31:0] EXC   = 32'h0000_0808;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid_i = 1'b0;
    logic [31:0] trap_cause_i = '0, trap_epc_i = '0, trap_tval_i = '0;
    logic [1:0] cur_priv_i = 2'd3;
    logic mie_i = 1'b0, sie_i = 1'b0, dbg_mode_i = 1'b0;
    logic ebrk_m_i = 1'b0, ebrk_s_i = 1'b0, ebrk_u_i = 1'b0;
    logic [31:0] edeleg_i = 32'h0000_010C;
    logic [31:0] ideleg_i = 32'h0000_0220;
    logic [31:0] mtvec_i = 32'h8000_0101;
    logic [31:0] stvec_i = 32'h4000_0200;
    logic upd_o, ie_o, pie_o;
    logic [1:0] path_o, priv_o, pp_o;
    logic [31:0] pc_o, cause_o, epc_o, tval_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        logic [1:0]  path;
        logic [31:0] pc;
        logic [1:0]  priv;
        logic [31:0] cause, epc, tval;
        logic        ie, pie;
        logic [1:0]  pp;
        string       tag;
    } exp_t;

    exp_t q[$];
    // model of the held record fields
    logic [31:0] m_cause = '0, m_epc = '0, m_tval = '0;
    logic        m_ie = 1'b0, m_pie = 1'b0;
    logic [1:0]  m_pp = 2'd0;

    always #2.5 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .DBG_ENTRY_ADDR(ENTRY), .DBG_EXC_ADDR(EXC),
                      .DBG_SWBP_CODE(1)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i),
        .trap_cause_i(trap_cause_i), .trap_epc_i(trap_epc_i), .trap_tval_i(trap_tval_i),
        .cur_priv_i(cur_priv_i), .mie_i(mie_i), .sie_i(sie_i), .dbg_mode_i(dbg_mode_i),
        .ebrk_m_i(ebrk_m_i), .ebrk_s_i(ebrk_s_i), .ebrk_u_i(ebrk_u_i),
        .edeleg_i(edeleg_i), .ideleg_i(ideleg_i), .mtvec_i(mtvec_i), .stvec_i(stvec_i),
        .upd_o(upd_o), .path_o(path_o), .pc_o(pc_o), .priv_o(priv_o),
        .cause_o(cause_o), .epc_o(epc_o), .tval_o(tval_o),
        .ie_o(ie_o), .pie_o(pie_o), .pp_o(pp_o)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply a request at a falling edge and queue its expected record.
    task automatic send(input logic [31:0] cause, input logic [31:0] epc,
                        input logic [31:0] tval, input logic [1:0] priv, input string tag);
        exp_t e;
        logic irq, bk, en, sup;
        logic [31:0] idx, mask;
        @(negedge clk);
        trap_valid_i = 1'b1; trap_cause_i = cause; trap_epc_i = epc;
        trap_tval_i = tval; cur_priv_i = priv;
        irq  = cause[31];
        idx  = {1'b0, cause[30:0]};
        mask = irq ? ideleg_i : edeleg_i;
        bk   = (cause == 32'd3);
        en   = (priv == 2'd0) ? ebrk_u_i : (priv == 2'd1) ? ebrk_s_i :
               (priv == 2'd3) ? ebrk_m_i : 1'b0;
        sup  = (priv <= 2'd1) && (idx < 32) && mask[idx[4:0]];
        e.tag = tag;
        if (dbg_mode_i) begin
            e.path = 2'd0; e.pc = bk ? ENTRY : EXC; e.priv = priv;
        end else if (bk && en) begin
            e.path = 2'd1; e.pc = ENTRY; e.priv = 2'd3;
            m_cause = 32'd1; m_epc = epc; m_pp = priv;
        end else if (sup) begin
            e.path = 2'd2; e.pc = stvec_i; e.priv = 2'd1;
            m_cause = cause; m_epc = epc; m_tval = tval; m_pie = sie_i; m_ie = 1'b0; m_pp = priv;
        end else begin
            e.path = 2'd3; e.priv = 2'd3;
            e.pc = {mtvec_i[31:1], 1'b0} + ((mtvec_i[0] && irq) ? idx * 4 : 32'd0);
            m_cause = cause; m_epc = epc; m_tval = tval; m_pie = mie_i; m_ie = 1'b0; m_pp = priv;
        end
        e.cause = m_cause; e.epc = m_epc; e.tval = m_tval;
        e.ie = m_ie; e.pie = m_pie; e.pp = m_pp;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trap_valid_i = 1'b0;
        end
    endtask

    // Monitor: compare each update record against the queue head.
    always @(negedge clk) begin
        if (rst_n && upd_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected upd_o", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(path_o == e.path, e.tag, "path", 32'(path_o), 32'(e.path));
                check(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
                check(priv_o == e.priv, e.tag, "priv", 32'(priv_o), 32'(e.priv));
                check({cause_o, epc_o, tval_o} == {e.cause, e.epc, e.tval}, e.tag,
                      "cause/epc/tval", cause_o ^ epc_o ^ tval_o, e.cause ^ e.epc ^ e.tval);
                check({ie_o, pie_o, pp_o} == {e.ie, e.pie, e.pp}, e.tag, "ie/pie/pp",
                      32'({ie_o, pie_o, pp_o}), 32'({e.ie, e.pie, e.pp}));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] pc_hold;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(upd_o == 1'b0, "R9", "upd_o", 32'(upd_o), 32'd0);
        check(pc_o == 32'd0, "R9", "pc_o", pc_o, 32'd0);
        check(priv_o == 2'd3, "R9", "priv_o", 32'(priv_o), 32'd3);
        rst_n = 1'b1;
        idle(2);

        // R6 R5: user exception index 2, delegated
        sie_i = 1'b1; mie_i = 1'b1;
        send(32'd2, 32'h1000, 32'hAA, 2'd0, "R6");
        idle(1);
        // R7 R8: same cause from machine, vectored mtvec but exception -> base
        send(32'd2, 32'h1004, 32'hBB, 2'd3, "R8");
        idle(1);
        // R4 R6: supervisor interrupt 5 via interrupt mask
        sie_i = 1'b0;
        send(32'h8000_0005, 32'h1008, 32'h0, 2'd1, "R4");
        idle(1);
        // R7: interrupt 7 not delegated -> vectored base + 28
        send(32'h8000_0007, 32'h100C, 32'h0, 2'd1, "R7");
        idle(1);
        // R4: exception 5 uses exception mask (bit clear) -> machine
        mie_i = 1'b0;
        send(32'd5, 32'h1010, 32'h11, 2'd0, "R4");
        idle(1);
        // R4: interrupt 2 uses interrupt mask (bit clear) -> machine
        send(32'h8000_0002, 32'h1014, 32'h0, 2'd0, "R4");
        idle(1);
        // R5: index 40 out of range even though low bits hit bit 8
        send(32'd40, 32'h1018, 32'h22, 2'd0, "R5");
        idle(1);
        // R3: breakpoint at supervisor with enable set -> debug entry
        ebrk_s_i = 1'b1;
        send(32'd3, 32'h101C, 32'h33, 2'd1, "R3");
        idle(1);
        // R10: breakpoint at user, its enable clear -> delegated (edeleg bit 3)
        ebrk_m_i = 1'b1;
        send(32'd3, 32'h1020, 32'h44, 2'd0, "R10");
        idle(1);
        // R2: debug active, breakpoint and other trap
        dbg_mode_i = 1'b1;
        send(32'd3, 32'h1024, 32'h55, 2'd3, "R2");
        idle(1);
        send(32'd2, 32'h1028, 32'h66, 2'd0, "R2");
        idle(1);
        dbg_mode_i = 1'b0;
        // R7: non-vectored machine interrupt -> plain base
        mtvec_i = 32'h2000_0000;
        send(32'h8000_0003, 32'h102C, 32'h0, 2'd3, "R7");
        idle(1);
        // R1: back-to-back requests
        sie_i = 1'b1;
        send(32'd8, 32'h1030, 32'h77, 2'd1, "R1");
        send(32'd1, 32'h1034, 32'h88, 2'd1, "R1");
        idle(3);
        // R1: outputs hold while idle
        pc_hold = pc_o;
        idle(4);
        check(upd_o == 1'b0, "R1", "idle upd_o", 32'(upd_o), 32'd0);
        check(pc_o == pc_hold, "R1", "idle pc_o", pc_o, pc_hold);
        check(q.size() == 0, "R1", "pending records", 32'(q.size()), 32'd0);
        finish_run();
    end
endmodule